// File: doc/BRIEF.md
# Comparator Event Interrupt Logic

This block turns a one-bit comparator decision into a sticky interrupt flag. The comparator result is a digital input. It reads 1 only when the positive analog input is strictly above the negative one. A 3-bit trigger mode selects the condition that raises the flag: a low level, a high level, a rising edge, a falling edge, or any change.

Three of the eight modes are debounced. They take a sample of the comparator only after two overflow ticks from an external timer have built up. The other modes take a sample on every enabled machine cycle. After the block is enabled, its first machine cycle only arms the sampler and takes no sample. Software clears the flag with a one-cycle clear pulse. Hardware can only set the flag.

Top module: `cmp_event_irq`

## Requirements
- R1: While reset is high, and on the first edge after it, `irq_flag` is 0. The stored previous sample, the armed state and the tick count are all cleared.
- R2: Mode 7 (binary 111) sets the flag on a sample where `cmp_out` is 1. Mode 0 (binary 000) sets it on a sample where `cmp_out` is 0. `cmp_out`=1 means the positive input is strictly greater than the negative input.
- R3: Modes 1 and 3 set the flag on a sample that reads 1 when the previous sample read 0. Modes 4 and 6 set it on a sample that reads 0 when the previous sample read 1.
- R4: Modes 2 and 5 set the flag on a sample that differs from the previous sample.
- R5: In modes 2, 3 and 6, each enabled armed cycle adds `ovf_tick` to a count. A sample is taken only on the cycle where the count reaches 2, and that cycle clears the count. In every other mode, each enabled armed cycle takes a sample and the count stays at 0.
- R6: On the first machine cycle with `cmp_enable` high after it was low (or after reset), the block arms itself, clears the tick count and takes no sample.
- R7: A machine cycle with `cmp_enable` low disarms the block, clears the tick count and never sets the flag.
- R8: The previous sample that edge and change detection use updates only on sample cycles.
- R9: A clock with `cycle_en` low leaves the armed state, the tick count and the previous sample unchanged, and never sets the flag.
- R10: A clock with `sw_clr` high clears the flag, unless the same clock also sets it; in that case the flag is 1.
- R11: Once set, the flag stays 1 until `sw_clr` is applied.
- R12: The flag changes on the clock edge that samples the triggering inputs: it is a register with one cycle of latency.

Sample results take effect at the clock edge where `cycle_en`, `cmp_enable` and the inputs are seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_en | input | 1 | Machine-cycle strobe; the block advances only when high |
| cmp_out | input | 1 | Comparator decision: 1 when positive input > negative input |
| cmp_enable | input | 1 | Comparator enable |
| trig_mode | input | 3 | Trigger mode, 0 to 7 |
| ovf_tick | input | 1 | One external timer overflow in this cycle |
| sw_clr | input | 1 | Software write of 0 to the flag; clears it |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Most faults in the hidden state show up as a flag that rises one sample early or late, or rises at the wrong time. A lost arming cycle lets the flag rise one machine cycle after enable instead of two. A tick count that does not reset moves every later debounced sample. A previous sample that updates off a sample cycle invents or hides an edge at the next sample. The bench sweeps every mode with varied stimulus against an arithmetic model and compares the flag after every clock. Any such fault therefore shows up within a few cycles of the stimulus that exposes it. Directed cases pin down the arming cycle, the two-tick debounce, the priority of set over clear, and a previous sample held across a cycle with no sample.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

  typedef enum logic [2:0] {
    TM_LEVEL_LOW  = 3'd0,
    TM_RISE       = 3'd1,
    TM_CHANGE_DB  = 3'd2,
    TM_RISE_DB    = 3'd3,
    TM_FALL       = 3'd4,
    TM_CHANGE     = 3'd5,
    TM_FALL_DB    = 3'd6,
    TM_LEVEL_HIGH = 3'd7
  } trig_mode_e;

  function automatic logic mode_debounced(trig_mode_e m);
    return (m == TM_CHANGE_DB) || (m == TM_RISE_DB) || (m == TM_FALL_DB);
  endfunction

  function automatic logic mode_fires(trig_mode_e m, logic prev, logic cur);
    logic f;
    case (m)
      TM_LEVEL_LOW:            f = ~cur;
      TM_LEVEL_HIGH:           f = cur;
      TM_RISE, TM_RISE_DB:     f = ~prev & cur;
      TM_FALL, TM_FALL_DB:     f = prev & ~cur;
      default:                 f = prev ^ cur;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/cmp_evt_sampler.sv
module cmp_evt_sampler #(
  parameter int DEB_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cycle_en,
  input  logic enable,
  input  logic debounced,
  input  logic tick,
  output logic armed,
  output logic sample
);
  localparam int CNT_W = $clog2(DEB_TICKS + 1);
  localparam int SUM_W = CNT_W + 1;

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] cnt_sum;
  logic             reach;

  always_comb begin
    cnt_sum = {1'b0, cnt_q} + SUM_W'(tick);
    reach   = (cnt_sum >= SUM_W'(DEB_TICKS));
    sample  = cycle_en & enable & armed_q & (~debounced | reach);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cycle_en) begin
      if (!enable) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!armed_q) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (!debounced || reach) begin
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_sum[CNT_W-1:0];
      end
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/cmp_evt_detect.sv
module cmp_evt_detect
  import cmp_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sample,
  input  trig_mode_e mode,
  input  logic       cmp_out,
  output logic       hit
);
  logic prev_q;

  always_comb hit = sample & mode_fires(mode, prev_q, cmp_out);

  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (sample) prev_q <= cmp_out;
  end
endmodule

// File: rtl/cmp_evt_flag.sv
module cmp_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= set | (flag_q & ~clr);
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_event_irq.sv
module cmp_event_irq
  import cmp_event_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int DEB_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_en,
  input  logic              cmp_out,
  input  logic              cmp_enable,
  input  logic [MODE_W-1:0] trig_mode,
  input  logic              ovf_tick,
  input  logic              sw_clr,
  output logic              irq_flag
);
  trig_mode_e mode;
  logic       debounced;
  logic       run_q;
  logic       sample_stb;
  logic       hit;

  assign mode      = trig_mode_e'(trig_mode[2:0]);
  assign debounced = mode_debounced(mode);

  cmp_evt_sampler #(.DEB_TICKS(DEB_TICKS)) u_sampler (
    .clk       (clk),
    .rst       (rst),
    .cycle_en  (cycle_en),
    .enable    (cmp_enable),
    .debounced (debounced),
    .tick      (ovf_tick),
    .armed     (run_q),
    .sample    (sample_stb)
  );

  cmp_evt_detect u_detect (
    .clk     (clk),
    .rst     (rst),
    .sample  (sample_stb),
    .mode    (mode),
    .cmp_out (cmp_out),
    .hit     (hit)
  );

  cmp_evt_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (hit),
    .clr  (sw_clr),
    .flag (irq_flag)
  );
endmodule

// File: rtl/cmp_event_irq_chk.sv
module cmp_event_irq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cycle_en,
  input logic       cmp_out,
  input logic       cmp_enable,
  input logic [2:0] trig_mode,
  input logic       ovf_tick,
  input logic       sw_clr,
  input logic       irq_flag,
  input logic       run_q,
  input logic       sample_stb,
  input logic       hit
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) assert_reset_clear_R1: assert (!irq_flag);
  end

  assert_level_high_R2: assert property (@(posedge clk) disable iff (rst)
    cycle_en && cmp_enable && run_q && trig_mode == 3'd7 && cmp_out |=> irq_flag);

  assert_debounce_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    sample_stb && (trig_mode == 3'd2 || trig_mode == 3'd3 || trig_mode == 3'd6) |-> ovf_tick);

  assert_no_startup_sample_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_en && cmp_enable && !run_q |-> !sample_stb);

  assert_rise_needs_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> $past(cycle_en && cmp_enable));

  assert_clear_works_R10: assert property (@(posedge clk) disable iff (rst)
    sw_clr && !hit |=> !irq_flag);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !sw_clr |=> irq_flag);
endmodule

bind cmp_event_irq cmp_event_irq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cycle_en   (cycle_en),
  .cmp_out    (cmp_out),
  .cmp_enable (cmp_enable),
  .trig_mode  (trig_mode[2:0]),
  .ovf_tick   (ovf_tick),
  .sw_clr     (sw_clr),
  .irq_flag   (irq_flag),
  .run_q      (run_q),
  .sample_stb (sample_stb),
  .hit        (hit)
);

// File: tb/cmp_event_irq_tb.sv
`timescale 1ns/1ps
module cmp_event_irq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cycle_en = 1'b0;
  logic       cmp_out = 1'b0;
  logic       cmp_enable = 1'b0;
  logic [2:0] trig_mode = 3'd0;
  logic       ovf_tick = 1'b0;
  logic       sw_clr = 1'b0;
  logic       irq_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // model state
  bit m_run, m_prev, m_flag;
  int m_cnt;

  always #4 clk = ~clk;

  cmp_event_irq u_dut (
    .clk(clk), .rst(rst), .cycle_en(cycle_en), .cmp_out(cmp_out),
    .cmp_enable(cmp_enable), .trig_mode(trig_mode), .ovf_tick(ovf_tick),
    .sw_clr(sw_clr), .irq_flag(irq_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq_flag actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit fires(int m, bit p, bit c);
    case (m)
      0: return !c;
      7: return c;
      1, 3: return !p && c;
      4, 6: return p && !c;
      default: return p != c;
    endcase
  endfunction

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(bit ce, bit en, int m, bit c, bit tk, bit clr, string tag);
    bit smp, h;
    @(negedge clk);
    cycle_en = ce; cmp_enable = en; trig_mode = 3'(m);
    cmp_out = c; ovf_tick = tk; sw_clr = clr;
    smp = 0; h = 0;
    if (ce) begin
      if (!en) begin m_run = 0; m_cnt = 0; end
      else if (!m_run) begin m_run = 1; m_cnt = 0; end
      else if (m == 2 || m == 3 || m == 6) begin
        if (m_cnt + int'(tk) >= 2) begin smp = 1; m_cnt = 0; end
        else m_cnt = m_cnt + int'(tk);
      end else smp = 1;
    end
    if (smp) begin h = fires(m, m_prev, c); m_prev = c; end
    m_flag = h || (m_flag && !clr);
    @(posedge clk);
    #2;
    chk(tag, irq_flag, m_flag);
  endtask

  initial begin
    bit [15:0] lf;
    m_run = 0; m_prev = 0; m_flag = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 flag in reset", irq_flag, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R6 startup cycle then R2 high level
    step(1, 1, 7, 1, 0, 0, "R6 arming cycle takes no sample");
    chk("R6 literal", irq_flag, 1'b0);
    step(1, 1, 7, 1, 0, 0, "R2 high level");
    chk("R2 literal", irq_flag, 1'b1);
    step(1, 1, 7, 0, 0, 0, "R11 sticky");
    step(1, 1, 7, 0, 0, 0, "R11 sticky");
    chk("R11 literal", irq_flag, 1'b1);
    step(1, 1, 7, 1, 0, 1, "R10 set wins over clear");
    chk("R10 literal set wins", irq_flag, 1'b1);
    step(1, 1, 7, 0, 0, 1, "R10 clear");
    chk("R10 literal clear", irq_flag, 1'b0);
    step(1, 0, 0, 0, 0, 0, "R7 disabled never sets");
    step(1, 0, 0, 0, 0, 0, "R7 disabled never sets");
    chk("R7 literal", irq_flag, 1'b0);
    step(1, 1, 0, 0, 0, 0, "R7 re-enable arms again");
    chk("R7 literal rearm", irq_flag, 1'b0);
    step(0, 1, 0, 0, 0, 0, "R9 idle cycle frozen");
    chk("R9 literal", irq_flag, 1'b0);
    step(1, 1, 0, 0, 0, 0, "R2 low level");
    chk("R2 literal low", irq_flag, 1'b1);
    step(1, 1, 3, 0, 0, 1, "R10 clear");
    // prev is 0 now; debounce rising edge
    step(1, 1, 3, 1, 0, 0, "R5 no tick no sample");
    step(1, 1, 3, 1, 1, 0, "R5 one tick no sample");
    chk("R5 literal one tick", irq_flag, 1'b0);
    step(0, 1, 3, 1, 1, 0, "R9 tick ignored when idle");
    chk("R9 literal tick", irq_flag, 1'b0);
    step(1, 1, 3, 1, 1, 0, "R5 second tick samples");
    chk("R5 literal second tick", irq_flag, 1'b1);
    step(1, 1, 3, 0, 0, 1, "R8 no sample");
    step(1, 1, 3, 1, 1, 0, "R8 one tick");
    step(1, 1, 3, 1, 1, 0, "R8 held prev hides edge");
    chk("R8 literal", irq_flag, 1'b0);
    step(1, 1, 1, 0, 0, 0, "R3 fall sample");
    step(1, 1, 1, 1, 0, 0, "R3 rising edge");
    chk("R3 literal", irq_flag, 1'b1);
    step(1, 1, 5, 0, 0, 1, "R4 change clears then fires");
    chk("R4 literal", irq_flag, 1'b1);

    // sweep every mode with pseudo-random stimulus
    lf = 16'hACE1;
    for (int m = 0; m < 8; m++) begin
      string tag;
      case (m)
        0, 7: tag = "R2 level sweep";
        1, 4: tag = "R3 edge sweep";
        5:    tag = "R4 change sweep";
        default: tag = "R5 debounce sweep";
      endcase
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[2:0] != 3'd0, lf[8:4] != 5'd0, m, lf[6] ^ lf[11],
             lf[9], lf[14:12] == 3'd0, tag);
      end
    end

    rst = 1'b1;
    m_run = 0; m_prev = 0; m_flag = 0; m_cnt = 0;
    @(posedge clk); #2;
    chk("R1 flag after reset", irq_flag, 1'b0);
    @(posedge clk); #2;
    chk("R12 flag still clear in reset", irq_flag, 1'b0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule